// File: doc/BRIEF.md
# Cipher-Round Glitch PUF Core

This block derives a 64-bit device fingerprint from the transient switching on the first rounds of a lightweight 64-bit block cipher. The cipher is unrolled and purely combinational. A challenge register feeds it. A 2-bit selector chooses one of four cut points inside the first two rounds, and every bit of the chosen cut clocks its own toggle flip-flop. On silicon, each tapped net settles through a spread of glitches. Each toggle flip-flop keeps the parity of the rising edges it has seen, and that parity becomes one response bit. Shallow cuts give repeatable answers. Deep cuts give more device-specific answers.

Use it like this: pulse `clear_i` to zero all toggle flip-flops, then pulse `launch_i` with a challenge and a 128-bit key applied. A fixed number of clock cycles later, `done_o` rises and the accumulated parities are latched onto `response_o`. Without a clear in between, a later launch adds its own edges to the parities already held.

Top module: `gpuf_round_tap`

## Requirements
- R1: While `rst_ni` is low, the challenge register, the toggle flip-flops, `response_o` and `done_o` are all zero.
- R2: The cipher input is the challenge register XOR `key_i[127:64]` XOR `key_i[63:0]` XOR the initial constant (all zero).
- R3: The substitution layer maps every nibble through the table 0→B, 1→F, 2→3, 3→2, 4→A, 5→C, 6→9, 7→1, 8→6, 9→7, A→8, B→0, C→E, D→5, E→D, F→4. For example, with a zero key, challenge 0123456789ABCDEF yields BF32AC916780E5D4 at the first cut.
- R4: A full round is the substitution layer, then the involutive 16-bit-chunk mixing layer, then the nibble reordering (output nibble i, counted from the MSB, takes input nibble 5·i mod 16), then XOR with round constant 13198A2E03707344 and `key_i[63:0]`.
- R5: `tap_sel_i` 0 selects the round-1 substitution output, 1 the complete round-1 output, 2 the round-2 substitution output, and 3 the round-2 mixing-layer output.
- R6: Each response bit is the parity of the rising transitions on its tapped net since the last clear: odd gives 1, even gives 0.
- R7: Falling transitions on a tapped net leave its toggle flip-flop unchanged.
- R8: `clear_i` asynchronously forces all toggle flip-flops to 0 and withdraws `done_o`.
- R9: `done_o` rises exactly SETTLE_CYCLES clock edges after the edge that samples `launch_i`. At that edge the toggle states are copied to `response_o`.
- R10: `response_o` changes only at the edge where `done_o` rises. Tap activity after that edge does not disturb the latched value or `done_o`.
- R11: A launch sampled during an evaluation drops `done_o` and restarts the settle count from that launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Asynchronous clear of the toggle flip-flops |
| launch_i | input | 1 | Loads the challenge and starts the settle count |
| challenge_i | input | 64 | Challenge word |
| key_i | input | 128 | Whitening key (upper half) and round key (lower half) |
| tap_sel_i | input | 2 | Cut-point select |
| response_o | output | 64 | Latched parity response |
| done_o | output | 1 | Response valid |

## Verification
The bench drives the challenge register through chosen sequences of values, so each tapped net sees a known pattern of rises and falls, and it compares every response bit against the predicted rising-edge parity.

Several directed cases target specific mistakes:
- A challenge that drives the first cut to all zeros, followed by a known challenge, exposes a wrong substitution table as a literal mismatch.
- Repeating a launch without a clear shows whether falling edges toggle, which would flip the parity.
- A clear between two identical launches must give all zeros. A missing clear would return the stale parity.
- Changing the key and selector after `done_o` would corrupt a response register that is not truly latched.
- An early relaunch would make a stale counter raise `done_o` too soon.

// File: rtl/gpuf_round_tap.sv
module gpuf_round_tap #(
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter logic [63:0] RC_INIT       = 64'h0000000000000000,
  parameter logic [63:0] RC_ROUND1     = 64'h13198a2e03707344
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         launch_i,
  input  logic [63:0]  challenge_i,
  input  logic [127:0] key_i,
  input  logic [1:0]   tap_sel_i,
  output logic [63:0]  response_o,
  output logic         done_o
);
  localparam int BLK   = 64;
  localparam int NIBS  = BLK / 4;
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  localparam logic [3:0] SBOX [16] = '{4'hB, 4'hF, 4'h3, 4'h2, 4'hA, 4'hC, 4'h9, 4'h1,
                                       4'h6, 4'h7, 4'h8, 4'h0, 4'hE, 4'h5, 4'hD, 4'h4};

  function automatic logic [BLK-1:0] sub_layer(input logic [BLK-1:0] x);
    logic [BLK-1:0] y;
    for (int i = 0; i < NIBS; i++) y[4*i +: 4] = SBOX[x[4*i +: 4]];
    return y;
  endfunction

  function automatic logic [15:0] mix16(input logic [15:0] x, input int h);
    logic [15:0] y;
    logic [3:0]  acc;
    for (int r = 0; r < 4; r++) begin
      acc = 4'h0;
      for (int c = 0; c < 4; c++)
        acc ^= x[15-4*c -: 4] & ~(4'b1000 >> ((r + c + h) % 4));
      y[15-4*r -: 4] = acc;
    end
    return y;
  endfunction

  function automatic logic [BLK-1:0] mix_layer(input logic [BLK-1:0] x);
    return {mix16(x[63:48], 0), mix16(x[47:32], 1), mix16(x[31:16], 1), mix16(x[15:0], 0)};
  endfunction

  function automatic logic [BLK-1:0] shift_layer(input logic [BLK-1:0] x);
    logic [BLK-1:0] y;
    int src;
    for (int i = 0; i < NIBS; i++) begin
      src = (i + 4 * (i % 4)) % NIBS;
      y[BLK-1-4*i -: 4] = x[BLK-1-4*src -: 4];
    end
    return y;
  endfunction

  logic [BLK-1:0]   gen_q, k_white, k_round;
  logic [BLK-1:0]   r0_in, s1_out, r1_out, s2_out, m2_out, tap;
  logic [BLK-1:0]   tff_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clr;

  assign k_white = key_i[127:64];
  assign k_round = key_i[63:0];
  assign r0_in   = gen_q ^ k_white ^ k_round ^ RC_INIT;
  assign s1_out  = sub_layer(r0_in);
  assign r1_out  = shift_layer(mix_layer(s1_out)) ^ RC_ROUND1 ^ k_round;
  assign s2_out  = sub_layer(r1_out);
  assign m2_out  = mix_layer(s2_out);

  always_comb begin
    unique case (tap_sel_i)
      2'd0:    tap = s1_out;
      2'd1:    tap = r1_out;
      2'd2:    tap = s2_out;
      default: tap = m2_out;
    endcase
  end

  assign clr = clear_i | ~rst_ni;

  for (genvar g = 0; g < BLK; g++) begin : g_tff
    logic t_q;
    always_ff @(posedge tap[g] or posedge clr) begin
      if (clr) t_q <= 1'b0;
      else     t_q <= ~t_q;
    end
    assign tff_q[g] = t_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q      <= '0;
      cnt_q      <= '0;
      done_o     <= 1'b0;
      response_o <= '0;
    end else if (launch_i) begin
      gen_q  <= challenge_i;
      cnt_q  <= CNT_W'(SETTLE_CYCLES);
      done_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        done_o     <= 1'b1;
        response_o <= tff_q;
      end
    end
  end

  logic [CNT_W:0] since_launch;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_launch <= '0;
    else if (launch_i)            since_launch <= '0;
    else if (since_launch != '1)  since_launch <= since_launch + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!done_o && response_o == '0));

  p_clear_zeroes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> (tff_q == '0));

  p_clear_drops_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !launch_i) |=> !done_o);

  p_done_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (since_launch == (CNT_W+1)'(SETTLE_CYCLES)));

  p_resp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(response_o) |-> $rose(done_o));

  p_relaunch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> !done_o);
endmodule

// File: tb/test_gpuf_round_tap.sv
`timescale 1ns/1ps
module test_gpuf_round_tap;
  localparam int S = 4;
  localparam logic [63:0] RCA = 64'h13198a2e03707344;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic         launch_i = 1'b0;
  logic [63:0]  challenge_i = '0;
  logic [127:0] key_i = '0;
  logic [1:0]   tap_sel_i = 2'd0;
  logic [63:0]  response_o;
  logic         done_o;

  gpuf_round_tap #(.SETTLE_CYCLES(S)) i_gpuf_round_tap (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .launch_i(launch_i),
    .challenge_i(challenge_i), .key_i(key_i), .tap_sel_i(tap_sel_i),
    .response_o(response_o), .done_o(done_o));

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [63:0] m_gen, m_prev, m_tff;

  function automatic logic [3:0] sb(input logic [3:0] v);
    case (v)
      4'h0: return 4'hB; 4'h1: return 4'hF; 4'h2: return 4'h3; 4'h3: return 4'h2;
      4'h4: return 4'hA; 4'h5: return 4'hC; 4'h6: return 4'h9; 4'h7: return 4'h1;
      4'h8: return 4'h6; 4'h9: return 4'h7; 4'hA: return 4'h8; 4'hB: return 4'h0;
      4'hC: return 4'hE; 4'hD: return 4'h5; 4'hE: return 4'hD; default: return 4'h4;
    endcase
  endfunction

  function automatic logic [63:0] ref_sub(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 16; i++) y[63-4*i -: 4] = sb(x[63-4*i -: 4]);
    return y;
  endfunction

  function automatic logic [63:0] ref_mix(input logic [63:0] x);
    logic [63:0] y;
    for (int q = 0; q < 64; q++) begin
      int ch, r, p, h;
      logic v;
      ch = q / 16; r = (q % 16) / 4; p = q % 4;
      h = (ch == 1 || ch == 2) ? 1 : 0;
      v = 1'b0;
      for (int c = 0; c < 4; c++)
        if (((r + c + h) % 4) != p) v ^= x[63 - (ch*16 + c*4 + p)];
      y[63-q] = v;
    end
    return y;
  endfunction

  function automatic logic [63:0] ref_sr(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 16; i++) y[63-4*i -: 4] = x[63-4*((5*i) % 16) -: 4];
    return y;
  endfunction

  function automatic logic [63:0] ref_tap(input logic [63:0] g, input logic [127:0] k, input logic [1:0] s);
    logic [63:0] a, b, c, d;
    a = ref_sub(g ^ k[127:64] ^ k[63:0]);
    b = ref_sr(ref_mix(a)) ^ RCA ^ k[63:0];
    c = ref_sub(b);
    d = ref_mix(c);
    case (s)
      2'd0: return a;
      2'd1: return b;
      2'd2: return c;
      default: return d;
    endcase
  endfunction

  task automatic upd();
    logic [63:0] nt;
    nt = ref_tap(m_gen, key_i, tap_sel_i);
    m_tff ^= nt & ~m_prev;
    m_prev = nt;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_launch(input logic [63:0] ch);
    @(negedge clk);
    challenge_i = ch;
    launch_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    launch_i = 1'b0;
    m_gen = ch;
    upd();
  endtask

  task automatic finish_eval(input string tag);
    repeat (S-1) @(posedge clk);
    @(negedge clk);
    chk("R9 done not early", {63'd0, done_o}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 done on time", {63'd0, done_o}, 64'd1);
    chk(tag, response_o, m_tff);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    m_tff = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 response in reset", response_o, 64'd0);
    chk("R1 done in reset", {63'd0, done_o}, 64'd0);
    rst_ni = 1'b1;
    m_gen = '0; m_tff = '0;
    m_prev = ref_tap(m_gen, key_i, tap_sel_i);

    // R3: drive cut 0 to all zeros, then clear and apply a known word
    do_launch({16{4'hB}});
    finish_eval("R6 no rises");
    do_clear();
    do_launch(64'h0123456789abcdef);
    finish_eval("R3 model");
    chk("R3 literal", response_o, 64'hbf32ac916780e5d4);

    // R7: falls only, parity unchanged
    do_launch({16{4'hB}});
    finish_eval("R7 falls ignored");
    chk("R7 literal", response_o, 64'hbf32ac916780e5d4);
    do_launch(64'h0123456789abcdef);
    finish_eval("R6 second rise set");
    chk("R6 parity even", response_o, 64'd0);

    // R8: clear between identical launches
    do_launch({16{4'hB}});
    finish_eval("R6 falls");
    do_launch(64'h0123456789abcdef);
    finish_eval("R6 odd");
    do_clear();
    chk("R8 clear drops done", {63'd0, done_o}, 64'd0);
    do_launch(64'h0123456789abcdef);
    finish_eval("R8 after clear");
    chk("R8 literal zero", response_o, 64'd0);

    // R10: activity after done must not disturb the latched response
    do_clear();
    do_launch(64'hfedcba9876543210);
    finish_eval("R6 pre-hold");
    held = response_o;
    @(negedge clk);
    key_i = {$urandom(), $urandom(), $urandom(), $urandom()};
    upd();
    @(negedge clk);
    tap_sel_i = 2'd3;
    upd();
    repeat (3) @(negedge clk);
    chk("R10 response held", response_o, held);
    chk("R10 done held", {63'd0, done_o}, 64'd1);

    // R11: relaunch in the middle of an evaluation
    do_clear();
    do_launch({$urandom(), $urandom()});
    @(posedge clk);
    @(posedge clk);
    do_launch({$urandom(), $urandom()});
    finish_eval("R11 restart");

    // R2 R4 R5: random keys, challenges and cut points
    for (int it = 0; it < 48; it++) begin
      logic [1:0] s;
      s = 2'(it % 4);
      @(negedge clk);
      key_i = {$urandom(), $urandom(), $urandom(), $urandom()};
      upd();
      @(negedge clk);
      tap_sel_i = s;
      upd();
      if ((it % 5) != 4) do_clear();
      do_launch({$urandom(), $urandom()});
      if ((it % 3) == 0) do_launch({$urandom(), $urandom()});
      if (s == 2'd1) finish_eval("R4 round1 cut");
      else finish_eval($sformatf("R2 R5 sel=%0d", s));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule